// File: doc/BRIEF.md
# Arbitrary IQ Playback Buffer

This block lets software replace the modulator output with a stored test waveform. Software writes 32-bit sample words one at a time. Each word carries a signed I component and a signed Q component. The words go into an on-chip FIFO. When the mode input selects arbitrary-IQ operation, a rising edge on the fire input starts one pass over the stored samples. During that pass one sample is emitted for each cycle in which the sample strobe is high. When the pass is complete the FIFO is empty and can be loaded again.

In normal mode the transmit outputs carry the normal modulator samples unchanged. In arbitrary-IQ mode the outputs carry the playback register. That register is zero whenever no playback is running. The expected use is to set the mode, load the words, and then raise the fire bit. A write that arrives while the FIFO is full is lost, and it sets a sticky overflow flag.

Top module: `iq_playback_top`

## Requirements
- R1: After reset, busy and overflow are low, the FIFO is empty, and with arb_mode high the outputs are zero.
- R2: With arb_mode low (0 = normal), out_i/out_q equal norm_i/norm_q in the same cycle.
- R3: The FIFO holds DEPTH (default 512) words. A write while it is full is dropped and sets overflow, which stays high until reset.
- R4: With arb_mode high (1 = arbitrary IQ) and a non-empty FIFO, a 0-to-1 change on fire raises busy on the next clock edge. Holding fire high does not start a second playback.
- R5: While busy, each clock edge with smp_strobe high loads the next word in write order onto the outputs, with I = bits 31:16 and Q = bits 15:0, both signed. The outputs hold their value between strobes.
- R6: The first strobe after the last word has been output returns the outputs to zero and drops busy. The FIFO is then empty, so a new fire edge does not set busy.
- R7: A fire edge while the FIFO is empty leaves busy low.
- R8: A fire edge while arb_mode is low is ignored, and the stored words are kept for a later playback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arb_mode | input | 1 | Source select: 0 = normal samples, 1 = arbitrary IQ |
| fire | input | 1 | A rising edge starts one playback |
| wr_en | input | 1 | Write strobe for wr_word |
| wr_word | input | 32 | Sample word: I in 31:16, Q in 15:0 |
| smp_strobe | input | 1 | Sample-rate enable |
| norm_i | input | 16 | Normal transmit I |
| norm_q | input | 16 | Normal transmit Q |
| busy | output | 1 | High during playback |
| overflow | output | 1 | Sticky flag for a dropped write |
| out_i | output | 16 | Transmit I |
| out_q | output | 16 | Transmit Q |

## Verification
The assertions assume that the inputs are synchronous to clk and free of X after reset. They also assume that fire, wr_en and smp_strobe are plain levels sampled at each edge; a pulse shorter than a cycle would not be seen. The bench drives every input on the falling edge and holds it for whole cycles. It starts strobes only after the cycle in which busy has been observed high. This keeps every start, pop and drop decision on a single, unambiguous clock edge.

// File: rtl/iq_pb_pkg.sv
package iq_pb_pkg;
  localparam int SMP_W  = 16;
  localparam int WORD_W = 2 * SMP_W;

  function automatic logic signed [SMP_W-1:0] word_i(input logic [WORD_W-1:0] w);
    return w[WORD_W-1:SMP_W];
  endfunction

  function automatic logic signed [SMP_W-1:0] word_q(input logic [WORD_W-1:0] w);
    return w[SMP_W-1:0];
  endfunction

  function automatic int unsigned ptr_step(input int unsigned p, input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/iq_sample_store.sv
module iq_sample_store
  import iq_pb_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int W     = WORD_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full,
  output logic                       empty,
  output logic                       push_drop
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign push_ok   = push && !full;
  assign push_drop = push && full;
  assign pop_ok    = pop && !empty;
  assign head      = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= AW'(ptr_step(int'(wr_ptr), DEPTH));
      if (pop_ok)  rd_ptr <= AW'(ptr_step(int'(rd_ptr), DEPTH));
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_drop_keeps_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(count));
endmodule

// File: rtl/iq_trig_edge.sv
module iq_trig_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise
);
  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl;
  end

  assign rise = lvl && !lvl_q;

  p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/iq_play_seq.sv
module iq_play_seq
  import iq_pb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              strobe,
  input  logic              src_empty,
  input  logic [WORD_W-1:0] src_word,
  output logic              pop,
  output logic              busy,
  output logic [WORD_W-1:0] play_word
);
  logic finish;

  assign pop    = busy && strobe && !src_empty;
  assign finish = busy && strobe && src_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      play_word <= '0;
    end else if (!busy) begin
      busy <= start_req;
    end else if (pop) begin
      play_word <= src_word;
    end else if (finish) begin
      play_word <= '0;
      busy      <= 1'b0;
    end
  end

  p_busy_needs_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_req));
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (play_word == '0));
  p_end_on_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> src_empty);
  p_hold_no_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !strobe) |=> $stable(play_word));
endmodule

// File: rtl/iq_playback_top.sv
module iq_playback_top
  import iq_pb_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    arb_mode,
  input  logic                    fire,
  input  logic                    wr_en,
  input  logic [WORD_W-1:0]       wr_word,
  input  logic                    smp_strobe,
  input  logic signed [SMP_W-1:0] norm_i,
  input  logic signed [SMP_W-1:0] norm_q,
  output logic                    busy,
  output logic                    overflow,
  output logic signed [SMP_W-1:0] out_i,
  output logic signed [SMP_W-1:0] out_q
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic              fire_rise, start_req, pop, full, empty, push_drop;
  logic [WORD_W-1:0] head, play_word;
  logic [CW-1:0]     count;

  iq_trig_edge edge_i (
    .clk(clk), .rst_n(rst_n), .lvl(fire), .rise(fire_rise)
  );

  iq_sample_store #(.DEPTH(DEPTH), .W(WORD_W)) store_i (
    .clk(clk), .rst_n(rst_n), .push(wr_en), .push_data(wr_word), .pop(pop),
    .head(head), .count(count), .full(full), .empty(empty), .push_drop(push_drop)
  );

  assign start_req = fire_rise && arb_mode && !empty;

  iq_play_seq seq_i (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .strobe(smp_strobe),
    .src_empty(empty), .src_word(head), .pop(pop), .busy(busy), .play_word(play_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         overflow <= 1'b0;
    else if (push_drop) overflow <= 1'b1;
  end

  always_comb begin
    if (arb_mode) begin
      out_i = word_i(play_word);
      out_q = word_q(play_word);
    end else begin
      out_i = norm_i;
      out_q = norm_q;
    end
  end

  p_overflow_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  p_overflow_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(wr_en && full));
  p_no_start_mode0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !arb_mode) |=> !busy);
endmodule

// File: tb/iq_playback_top_tb_top.sv
module iq_playback_top_tb_top;
  localparam int DEPTH = 512;

  logic clk = 1'b0;
  logic rst_n, arb_mode, fire, wr_en, smp_strobe;
  logic [31:0] wr_word;
  logic signed [15:0] norm_i, norm_q;
  logic busy, overflow;
  logic signed [15:0] out_i, out_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] expq[$];

  always #2 clk = ~clk;

  iq_playback_top #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .arb_mode(arb_mode), .fire(fire), .wr_en(wr_en),
    .wr_word(wr_word), .smp_strobe(smp_strobe), .norm_i(norm_i), .norm_q(norm_q),
    .busy(busy), .overflow(overflow), .out_i(out_i), .out_q(out_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; arb_mode = 0; fire = 0; wr_en = 0; smp_strobe = 0;
    wr_word = '0; norm_i = '0; norm_q = '0;
    expq.delete();
    repeat (3) tick();
    rst_n = 1;
    tick();
  endtask

  task automatic write_word(input logic [31:0] w);
    wr_en = 1; wr_word = w;
    tick();
    wr_en = 0;
  endtask

  task automatic pulse_fire();
    fire = 1; tick(); fire = 0; tick();
  endtask

  task automatic strobe_once();
    smp_strobe = 1; tick(); smp_strobe = 0;
  endtask

  task automatic play_and_check(input string req);
    while (expq.size() > 0) begin
      logic [31:0] w;
      w = expq.pop_front();
      strobe_once();
      chk(req, {out_i, out_q}, w);
      tick();
      chk({req, " hold"}, {out_i, out_q}, w);
    end
    strobe_once();
    chk("R6 zero after end", {out_i, out_q}, 32'h0);
    chk("R6 busy low after end", {31'b0, busy}, 32'h0);
  endtask

  task automatic t_reset_r1();
    do_reset();
    chk("R1 busy", {31'b0, busy}, 0);
    chk("R1 overflow", {31'b0, overflow}, 0);
    arb_mode = 1; norm_i = 16'h1234; norm_q = 16'h5678; tick();
    chk("R1 zero out in arb mode", {out_i, out_q}, 32'h0);
  endtask

  task automatic t_normal_r2();
    arb_mode = 0;
    for (int k = 0; k < 4; k++) begin
      norm_i = 16'(k * 3001 - 5000); norm_q = 16'(~k * 77);
      #1;
      chk("R2 passthrough", {out_i, out_q}, {norm_i, norm_q});
      tick();
    end
  endtask

  task automatic t_play_r4_r5();
    do_reset();
    arb_mode = 1;
    for (int k = 0; k < 6; k++) begin
      logic [31:0] w;
      w = {16'(16'h8000 + k * 257), 16'(16'h7fff - k * 1000)};
      write_word(w); expq.push_back(w);
    end
    fire = 1; tick();
    chk("R4 busy after edge", {31'b0, busy}, 1);
    tick(); tick();
    chk("R4 held fire keeps busy once", {31'b0, busy}, 1);
    fire = 0;
    play_and_check("R5 sample order");
    fire = 1; tick();
    chk("R6 refire after empty", {31'b0, busy}, 0);
    fire = 0; tick();
  endtask

  task automatic t_empty_r7();
    do_reset();
    arb_mode = 1;
    pulse_fire();
    chk("R7 empty fire", {31'b0, busy}, 0);
  endtask

  task automatic t_mode0_r8();
    do_reset();
    arb_mode = 0;
    write_word(32'hA5A5_0001); expq.push_back(32'hA5A5_0001);
    write_word(32'h0002_FFFE); expq.push_back(32'h0002_FFFE);
    pulse_fire();
    chk("R8 mode0 fire ignored", {31'b0, busy}, 0);
    arb_mode = 1;
    pulse_fire();
    chk("R8 words kept, later start", {31'b0, busy}, 1);
    play_and_check("R8 kept order");
  endtask

  task automatic t_overflow_r3();
    do_reset();
    arb_mode = 1;
    for (int k = 0; k < DEPTH; k++) begin
      logic [31:0] w;
      w = {16'(k), 16'(-k)};
      write_word(w); expq.push_back(w);
    end
    chk("R3 no overflow at capacity", {31'b0, overflow}, 0);
    write_word(32'hDEAD_BEEF);
    chk("R3 overflow set", {31'b0, overflow}, 1);
    pulse_fire();
    play_and_check("R3 full playback");
    chk("R3 overflow sticky", {31'b0, overflow}, 1);
  endtask

  initial begin
    t_reset_r1();
    t_normal_r2();
    t_play_r4_r5();
    t_empty_r7();
    t_mode0_r8();
    t_overflow_r3();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule